// File: doc/BRIEF.md
# Firmware Memory Read Target

This block is the target side of a 4-bit multiplexed address/data bus, and it answers single-byte firmware memory reads. Every field is taken from the nibble lines on the rising edge of the bus clock. A cycle is opened by an active-low frame strobe. The start code is the nibble present in the last clock of the low strobe. If that code marks a firmware memory read, the block compares the next nibble, the ID select, against a 4-bit strap input.

When the ID select matches, the block shifts in a 28-bit address over seven clocks, most-significant nibble first, and then checks the size nibble. For a one-byte size it issues a single read strobe on a synchronous byte-read port. It then drives the response in this order: the second turnaround clock, a ready-sync nibble, the data byte low nibble first, and a closing all-ones nibble. After that it releases the bus, so the whole cycle takes 17 clocks. A wrong start code, a wrong ID or a wrong size sends the block back to waiting without enabling its drivers. A new low frame strobe or a reset stops any cycle in progress.

Top module: `fwh_read_target`

## Requirements
- R1: The block responds only when the start nibble, sampled with frame_ni low, is 4'b1101. Any other start nibble gives no response and no read strobe.
- R2: While frame_ni is held low for several clocks, only the nibble of the last low clock is taken as the start code.
- R3: The nibble in the clock after the start code must equal id_strap_i. On a mismatch lad_oe_o stays low for the whole cycle.
- R4: The seven nibbles in clocks 3 to 9 form the address, clock 3 carrying bits 27:24. mem_addr_o presents the low ADDR_W bits of that address.
- R5: A size nibble in clock 10 other than 4'b0000 gives no read strobe, and lad_oe_o stays low.
- R6: After a valid size, lad_oe_o first rises for clock 12, the second turnaround clock, and lad_o carries 4'b1111 in that clock.
- R7: In clock 13 the block drives the ready-sync nibble 4'b0000.
- R8: Clock 14 carries bits 3:0 of the byte read, and clock 15 carries bits 7:4.
- R9: In clock 16 the block drives 4'b1111. lad_oe_o is low from clock 17, so the output is enabled for exactly five clocks.
- R10: frame_ni sampled low during any clock of a cycle drops lad_oe_o in the next clock and starts start-code detection again with that nibble.
- R11: While rst_ni is low, lad_oe_o and mem_re_o are low. Asserting rst_ni in the middle of a cycle releases the bus at once.
- R12: mem_re_o is a one-clock pulse, high during clock 11 of a valid cycle. mem_rdata_i is expected on the clock after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous bus reset |
| frame_ni | input | 1 | Active-low frame strobe |
| lad_i | input | 4 | Nibble lines as seen by the target |
| id_strap_i | input | 4 | Device ID strap compared with the ID select field |
| lad_o | output | 4 | Nibble value driven by the target |
| lad_oe_o | output | 1 | Output enable for lad_o |
| mem_re_o | output | 1 | One-clock read strobe to the local byte array |
| mem_addr_o | output | ADDR_W | Byte address for the read |
| mem_rdata_i | input | 8 | Read data, valid the clock after mem_re_o |

## Verification
A sequencer that has lost its place shows up on lad_oe_o or lad_o within one or two clocks of the slip. The enable rises a clock early or late against the second turnaround, the sync nibble lands in a data slot, or the five-clock drive window grows or shrinks. Each of these is checked by position, counting from the start clock. A wrong address shift or a bad nibble count appears at the read strobe in clock 11, either as a wrong mem_addr_o or as a strobe in the wrong clock. A bad capture of the data register appears in the byte put together from clocks 14 and 15. Abort and reset faults show as the enable staying high in the clock after frame_ni goes low or rst_ni is asserted.

// File: rtl/fwh_pkg.sv
package fwh_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_START, S_ADDR, S_SIZE, S_TAR0,
    S_TAR1, S_SYNC, S_DLO, S_DHI, S_TARE
  } fwh_state_e;

  localparam logic [3:0] START_MEM_RD = 4'hD;
  localparam logic [3:0] SIZE_ONE     = 4'h0;
  localparam logic [3:0] NIB_ONES     = 4'hF;
  localparam logic [3:0] SYNC_READY   = 4'h0;
endpackage

// File: rtl/fwh_seq.sv
module fwh_seq
  import fwh_pkg::*;
#(
  parameter int NIBBLES = 7
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       frame_ni,
  input  logic [3:0] lad_i,
  input  logic [3:0] id_strap_i,
  output fwh_state_e state_o,
  output logic       shift_o,
  output logic       mem_re_o
);
  localparam int CW = (NIBBLES > 1) ? $clog2(NIBBLES) : 1;
  localparam logic [CW-1:0] LAST_NIB = CW'(NIBBLES - 1);

  fwh_state_e state_q, state_d;
  logic [CW-1:0] cnt_q;
  logic          re_q;

  always_comb begin
    state_d = state_q;
    if (!frame_ni) begin
      // last low-frame nibble decides; earlier ones are overwritten
      state_d = (lad_i == START_MEM_RD) ? S_START : S_IDLE;
    end else begin
      unique case (state_q)
        S_IDLE:  state_d = S_IDLE;
        S_START: state_d = (lad_i == id_strap_i) ? S_ADDR : S_IDLE;
        S_ADDR:  state_d = (cnt_q == LAST_NIB) ? S_SIZE : S_ADDR;
        S_SIZE:  state_d = (lad_i == SIZE_ONE) ? S_TAR0 : S_IDLE;
        S_TAR0:  state_d = S_TAR1;
        S_TAR1:  state_d = S_SYNC;
        S_SYNC:  state_d = S_DLO;
        S_DLO:   state_d = S_DHI;
        S_DHI:   state_d = S_TARE;
        S_TARE:  state_d = S_IDLE;
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      re_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      re_q    <= frame_ni && (state_q == S_SIZE) && (lad_i == SIZE_ONE);
      if (frame_ni && state_q == S_ADDR) cnt_q <= cnt_q + 1'b1;
      else                               cnt_q <= '0;
    end
  end

  assign state_o  = state_q;
  assign shift_o  = frame_ni && (state_q == S_ADDR);
  assign mem_re_o = re_q;

  p_re_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> !mem_re_o);

  p_start_last_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_START) |-> $past(!frame_ni));

  p_size_after_addr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_SIZE) |-> ($past(state_q) == S_ADDR && $past(cnt_q) == LAST_NIB));

  p_abort_restart_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_ni |=> (state_q == S_START || state_q == S_IDLE));
endmodule

// File: rtl/fwh_addr_collect.sv
module fwh_addr_collect #(
  parameter int ADDR_W = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic [3:0]        lad_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;

  generate
    if (ADDR_W > 4) begin : g_wide
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      addr_q <= '0;
        else if (shift_i) addr_q <= {addr_q[ADDR_W-5:0], lad_i};
      end
    end else begin : g_narrow
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      addr_q <= '0;
        else if (shift_i) addr_q <= lad_i[ADDR_W-1:0];
      end
    end
  endgenerate

  assign addr_o = addr_q;

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(addr_o));
endmodule

// File: rtl/fwh_rsp_drive.sv
module fwh_rsp_drive
  import fwh_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       frame_ni,
  input  fwh_state_e state_i,
  input  logic [7:0] mem_rdata_i,
  output logic [3:0] lad_o,
  output logic       lad_oe_o
);
  logic [7:0] data_q;
  logic [3:0] lad_q;
  logic       oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      lad_q  <= NIB_ONES;
      oe_q   <= 1'b0;
    end else if (!frame_ni) begin
      lad_q <= NIB_ONES;
      oe_q  <= 1'b0;
    end else begin
      unique case (state_i)
        S_TAR0: begin
          oe_q  <= 1'b1;
          lad_q <= NIB_ONES;
        end
        S_TAR1: begin
          data_q <= mem_rdata_i;
          lad_q  <= SYNC_READY;
        end
        S_SYNC: lad_q <= data_q[3:0];
        S_DLO:  lad_q <= data_q[7:4];
        S_DHI:  lad_q <= NIB_ONES;
        S_TARE: begin
          oe_q  <= 1'b0;
          lad_q <= NIB_ONES;
        end
        default: oe_q <= 1'b0;
      endcase
    end
  end

  assign lad_o    = lad_q;
  assign lad_oe_o = oe_q;

  p_abort_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_ni |=> !lad_oe_o);

  p_oe_rise_ones_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lad_oe_o) |-> (lad_o == NIB_ONES));

  p_sync_after_tar_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lad_oe_o && $past(lad_oe_o) && !$past(lad_oe_o, 2)) |-> (lad_o == SYNC_READY));
endmodule

// File: rtl/fwh_read_target.sv
module fwh_read_target
  import fwh_pkg::*;
#(
  parameter int ADDR_W  = 19,
  parameter int NIBBLES = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_ni,
  input  logic [3:0]        lad_i,
  input  logic [3:0]        id_strap_i,
  output logic [3:0]        lad_o,
  output logic              lad_oe_o,
  output logic              mem_re_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_rdata_i
);
  fwh_state_e state;
  logic       shift;

  fwh_seq #(.NIBBLES(NIBBLES)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .frame_ni   (frame_ni),
    .lad_i      (lad_i),
    .id_strap_i (id_strap_i),
    .state_o    (state),
    .shift_o    (shift),
    .mem_re_o   (mem_re_o)
  );

  fwh_addr_collect #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (shift),
    .lad_i   (lad_i),
    .addr_o  (mem_addr_o)
  );

  fwh_rsp_drive u_drv (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_ni    (frame_ni),
    .state_i     (state),
    .mem_rdata_i (mem_rdata_i),
    .lad_o       (lad_o),
    .lad_oe_o    (lad_oe_o)
  );

  p_drive_after_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lad_oe_o) |-> $past(mem_re_o));

  p_addr_stable_read_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |-> $stable(mem_addr_o));
endmodule

// File: tb/sim_fwh_read_target.sv
module sim_fwh_read_target;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 19;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame_n = 1'b1;
  logic [3:0]    lad_in = 4'hF;
  logic [3:0]    id_strap = 4'h5;
  logic [3:0]    lad_out;
  logic          lad_oe;
  logic          mem_re;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_rdata = 8'h00;

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;
  bit  skip_run = 0;
  logic [7:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fwh_read_target #(.ADDR_W(AW), .NIBBLES(7)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .frame_ni(frame_n), .lad_i(lad_in),
    .id_strap_i(id_strap), .lad_o(lad_out), .lad_oe_o(lad_oe),
    .mem_re_o(mem_re), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [7:0] mem_fn(input logic [AW-1:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ {5'd0, a[18:16]} ^ 8'h3C;
  endfunction

  always @(posedge clk) if (mem_re) mem_rdata <= mem_fn(mem_addr);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: collects each drive window and compares against the scoreboard
  int         run_len = 0;
  logic [3:0] nib_s [0:4];
  always @(negedge clk) begin
    if (lad_oe) begin
      if (run_len < 5) nib_s[run_len] = lad_out;
      run_len++;
    end else if (run_len > 0) begin
      if (skip_run) skip_run = 0;
      else if (exp_q.size() == 0) chk(0, "R1 unexpected response", run_len, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(run_len == 5, "R9 drive window length", run_len, 5);
        chk(nib_s[0] == 4'hF, "R6 turnaround nibble", nib_s[0], 4'hF);
        chk(nib_s[1] == 4'h0, "R7 sync nibble", nib_s[1], 4'h0);
        chk({nib_s[3], nib_s[2]} == e, "R8 data byte", {nib_s[3], nib_s[2]}, e);
        chk(nib_s[4] == 4'hF, "R9 closing nibble", nib_s[4], 4'hF);
      end
      run_len = 0;
    end
  end

  task automatic nib(input logic f, input logic [3:0] v);
    @(negedge clk);
    frame_n = f;
    lad_in  = v;
  endtask

  task automatic host_read(input bit with_start, input logic [3:0] st, input logic [3:0] idv,
                           input logic [27:0] a, input logic [3:0] sz, input bit resp,
                           input string tag);
    if (with_start) nib(1'b0, st);
    nib(1'b1, idv);
    for (int i = 6; i >= 0; i--) nib(1'b1, a[4*i +: 4]);
    nib(1'b1, sz);
    nib(1'b1, 4'hF); // clock 11
    chk(mem_re == resp, {tag, " read strobe clock 11 (R12)"}, mem_re, resp);
    if (resp) begin
      chk(mem_addr == a[AW-1:0], "R4 address", mem_addr, a[AW-1:0]);
      exp_q.push_back(mem_fn(a[AW-1:0]));
    end
    chk(lad_oe == 1'b0, {tag, " no drive in clock 11 (R6)"}, lad_oe, 0);
    nib(1'b1, 4'hF); // clock 12
    chk(lad_oe == resp, {tag, " drive enable clock 12"}, lad_oe, resp);
    chk(mem_re == 1'b0, "R12 strobe one clock", mem_re, 0);
    for (int c = 13; c <= 16; c++) begin
      nib(1'b1, 4'hF);
      if (c == 16) chk(lad_oe == resp, {tag, " drive enable clock 16 (R9)"}, lad_oe, resp);
    end
    nib(1'b1, 4'hF); // clock 17
    chk(lad_oe == 1'b0, "R9 released in clock 17", lad_oe, 0);
    nib(1'b1, 4'hF);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(lad_oe == 1'b0, "R11 reset enable", lad_oe, 0);
    chk(mem_re == 1'b0, "R11 reset strobe", mem_re, 0);
    rst_n = 1'b1;
    repeat (2) nib(1'b1, 4'hF);

    // R1, R4, R6..R9, R12 basic reads
    host_read(1, 4'hD, 4'h5, 28'h0001234, 4'h0, 1, "R1");
    host_read(1, 4'hD, 4'h5, 28'hFFFFFFF, 4'h0, 1, "R1");
    host_read(1, 4'hD, 4'h5, 28'hA5C3E71, 4'h0, 1, "R8");
    // R1 wrong start code
    host_read(1, 4'hC, 4'h5, 28'h0001234, 4'h0, 0, "R1");
    // R3 ID mismatch
    host_read(1, 4'hD, 4'h6, 28'h0004321, 4'h0, 0, "R3");
    // R5 bad size
    host_read(1, 4'hD, 4'h5, 28'h0004321, 4'h1, 0, "R5");
    // R2 held strobe: last low nibble counts
    nib(1'b0, 4'h0);
    host_read(1, 4'hD, 4'h5, 28'h0007BCD, 4'h0, 1, "R2");
    nib(1'b0, 4'hD);
    host_read(1, 4'h0, 4'h5, 28'h0007BCD, 4'h0, 0, "R2");
    // R3 other strap value
    id_strap = 4'hA;
    host_read(1, 4'hD, 4'hA, 28'h0050F0F, 4'h0, 1, "R3");

    // R10 abort in sync clock, new start nibble restarts a cycle
    nib(1'b0, 4'hD);
    nib(1'b1, 4'hA);
    for (int i = 6; i >= 0; i--) nib(1'b1, 4'h3);
    nib(1'b1, 4'h0);
    nib(1'b1, 4'hF);
    nib(1'b1, 4'hF);
    chk(lad_oe == 1'b1, "R10 driving before abort", lad_oe, 1);
    skip_run = 1;
    nib(1'b0, 4'hD); // clock 13: abort and new start
    nib(1'b1, 4'hA);
    chk(lad_oe == 1'b0, "R10 released after abort", lad_oe, 0);
    for (int i = 6; i >= 0; i--) nib(1'b1, 4'h2);
    nib(1'b1, 4'h0);
    nib(1'b1, 4'hF);
    chk(mem_re == 1'b1, "R10 restarted cycle strobe", mem_re, 1);
    exp_q.push_back(mem_fn(19'h22222));
    repeat (7) nib(1'b1, 4'hF);
    chk(lad_oe == 1'b0, "R10 restarted cycle released", lad_oe, 0);

    // R11 reset mid-cycle
    nib(1'b0, 4'hD);
    nib(1'b1, 4'hA);
    for (int i = 6; i >= 0; i--) nib(1'b1, 4'h1);
    nib(1'b1, 4'h0);
    nib(1'b1, 4'hF);
    nib(1'b1, 4'hF);
    skip_run = 1;
    #1 rst_n = 1'b0;
    #1 chk(lad_oe == 1'b0, "R11 reset releases bus", lad_oe, 0);
    nib(1'b1, 4'hF);
    rst_n = 1'b1;
    repeat (2) nib(1'b1, 4'hF);
    host_read(1, 4'hD, 4'hA, 28'h0012345, 4'h0, 1, "R11");

    repeat (3) nib(1'b1, 4'hF);
    chk(exp_q.size() == 0, "R8 all expected reads seen", exp_q.size(), 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule